// File: doc/BRIEF.md
# Bank-Aware Out-of-Order Memory Scheduler

This block takes read and write requests from a host bus and holds them in a small age-ordered queue. Each cycle it sends at most one command to a multi-bank SDRAM controller. It picks the oldest queued request whose bank is idle, so a request that waits on a busy bank does not stall traffic to the other banks.

Writes are posted: they are acknowledged in the cycle they are offered and need nothing more from the host. Reads are deferred. An accepted read is given a transaction tag at once, and from that point it counts as globally visible. Its data comes back later on a completion channel, marked with that tag, in any order relative to other reads.

While a deferred read to a cache line is outstanding, the block answers any coherent write to that line with retry. The retries continue until the read's completion has been handed to the host. The block keeps a per-bank busy timer, and the controller returns read data to it on a tagged return port.

Top module: `mem_sched`

## Requirements
- R1: An accepted read is answered in its request cycle with `rsp_accept` high and the lowest-numbered free tag on `rsp_tag`. Tags run 0 to 15, and a tag stays in use until its completion handshake.
- R2: A read is retried when all 16 tags are in use. Any request is retried when the 8-entry queue is full, even if a dispatch happens in the same cycle.
- R3: A write that is not retried is acknowledged with `rsp_accept` in its request cycle and takes no tag.
- R4: A write with `req_coh` high is retried when its line matches the line of an outstanding read. The line is `req_addr[31:6]`. The retries continue through the cycle of that read's completion handshake, and the write is accepted from the next cycle. A write with `req_coh` low, and a coherent write to another line, are accepted.
- R5: The bank of a request is `addr[5:4]`. After a command to a bank, no command goes to that bank for the next 4 cycles. A bank idle since then can take a command in the 5th cycle.
- R6: A queued request is dispatched in the cycle after its acceptance if its bank is free. When more than one request can go, the oldest whose bank is free goes first, so later requests to free banks bypass one blocked on a busy bank.
- R7: Requests to the same bank are dispatched in arrival order. A read that follows a posted write to the same address returns the written data.
- R8: `cpl_valid` stays high with `cpl_tag` and `cpl_data` unchanged until `cpl_ready` is high. Each accepted read completes exactly once, with the data returned for its tag.
- R9: After reset, no command or completion is presented, all banks are idle, and all tags are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_coh | input | 1 | Write is coherent |
| req_addr | input | 32 | Request byte address |
| req_wdata | input | 64 | Write data |
| rsp_accept | output | 1 | Request taken this cycle |
| rsp_retry | output | 1 | Request refused, host must reissue |
| rsp_tag | output | 4 | Tag given to an accepted read |
| cmd_valid | output | 1 | Command to the SDRAM controller this cycle |
| cmd_we | output | 1 | Command is a write |
| cmd_bank | output | 2 | Target bank |
| cmd_addr | output | 32 | Command address |
| cmd_wdata | output | 64 | Command write data |
| cmd_tag | output | 4 | Tag of a read command |
| bank_busy | output | 4 | Per-bank busy indication |
| dram_rvalid | input | 1 | Controller returns read data |
| dram_rtag | input | 4 | Tag of returned data |
| dram_rdata | input | 64 | Returned data |
| cpl_valid | output | 1 | Completion presented |
| cpl_ready | input | 1 | Host takes the completion |
| cpl_tag | output | 4 | Completion tag |
| cpl_data | output | 64 | Completion data |

## Verification
Two actions can land in the same cycle: the host accepting a completion, and a coherent write to that completion's line asking for entry. The bench sets this up by leaving a completion waiting with `cpl_ready` low. It then raises `cpl_ready` in the same cycle that it offers the coherent write. It expects a retry in that cycle and acceptance of the identical write in the next. A second same-cycle pairing, a dispatch and an insertion against a full queue, is driven by back-to-back writes to one bank. There the bench predicts exactly which attempt sees the first retry.

// File: rtl/mem_sched.sv
module mem_sched #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 64,
  parameter int TAG_W    = 4,
  parameter int QDEPTH   = 8,
  parameter int NBANK    = 4,
  parameter int BANK_LSB = 4,
  parameter int LINE_LSB = 6,
  parameter int BUSY_CYC = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         req_we,
  input  logic                         req_coh,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [DATA_W-1:0]            req_wdata,
  output logic                         rsp_accept,
  output logic                         rsp_retry,
  output logic [TAG_W-1:0]             rsp_tag,
  output logic                         cmd_valid,
  output logic                         cmd_we,
  output logic [$clog2(NBANK)-1:0]     cmd_bank,
  output logic [ADDR_W-1:0]            cmd_addr,
  output logic [DATA_W-1:0]            cmd_wdata,
  output logic [TAG_W-1:0]             cmd_tag,
  output logic [NBANK-1:0]             bank_busy,
  input  logic                         dram_rvalid,
  input  logic [TAG_W-1:0]             dram_rtag,
  input  logic [DATA_W-1:0]            dram_rdata,
  output logic                         cpl_valid,
  input  logic                         cpl_ready,
  output logic [TAG_W-1:0]             cpl_tag,
  output logic [DATA_W-1:0]            cpl_data
);
  localparam int NTAG   = 1 << TAG_W;
  localparam int BANK_W = $clog2(NBANK);
  localparam int IDX_W  = $clog2(QDEPTH);
  localparam int CNT_W  = $clog2(QDEPTH + 1);
  localparam int BC_W   = $clog2(BUSY_CYC + 1);
  localparam int LINE_W = ADDR_W - LINE_LSB;

  typedef struct packed {
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [TAG_W-1:0]  tag;
  } qent_t;

  qent_t              q [QDEPTH];
  logic [CNT_W-1:0]   q_cnt;
  logic [NTAG-1:0]    t_busy, t_rdy;
  logic [LINE_W-1:0]  t_line [NTAG];
  logic [DATA_W-1:0]  t_data [NTAG];

  logic               pick_ok, tag_ok, conflict, q_full, cpl_fire;
  logic [IDX_W-1:0]   pick;
  logic [TAG_W-1:0]   ftag, sel;
  logic [NTAG-1:0]    cand;
  logic [CNT_W-1:0]   wr_idx;

  always_comb begin
    pick_ok = 1'b0;
    pick    = '0;
    for (int i = QDEPTH - 1; i >= 0; i--)
      if (CNT_W'(i) < q_cnt && !bank_busy[q[i].addr[BANK_LSB +: BANK_W]]) begin
        pick_ok = 1'b1;
        pick    = IDX_W'(i);
      end
  end

  always_comb begin
    tag_ok   = 1'b0;
    ftag     = '0;
    conflict = 1'b0;
    for (int t = NTAG - 1; t >= 0; t--) begin
      if (!t_busy[t]) begin
        tag_ok = 1'b1;
        ftag   = TAG_W'(t);
      end
      if (t_busy[t] && t_line[t] == req_addr[ADDR_W-1:LINE_LSB]) conflict = 1'b1;
    end
  end

  assign q_full     = (q_cnt == CNT_W'(QDEPTH));
  assign rsp_accept = req_valid && !q_full && (req_we ? !(req_coh && conflict) : tag_ok);
  assign rsp_retry  = req_valid && !rsp_accept;
  assign rsp_tag    = req_we ? '0 : ftag;

  assign cmd_valid  = pick_ok;
  assign cmd_we     = q[pick].we;
  assign cmd_addr   = q[pick].addr;
  assign cmd_wdata  = q[pick].wdata;
  assign cmd_tag    = q[pick].tag;
  assign cmd_bank   = q[pick].addr[BANK_LSB +: BANK_W];

  assign wr_idx = q_cnt - CNT_W'(cmd_valid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_cnt <= '0;
    end else begin
      for (int i = 0; i < QDEPTH - 1; i++)
        if (cmd_valid && i >= int'(pick)) q[i] <= q[i+1];
      if (rsp_accept)
        q[IDX_W'(wr_idx)] <= '{we: req_we, addr: req_addr, wdata: req_wdata, tag: rsp_tag};
      q_cnt <= q_cnt + CNT_W'(rsp_accept) - CNT_W'(cmd_valid);
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [BC_W-1:0] bcnt;
    always_ff @(posedge clk) begin
      if (!rst_n)                                    bcnt <= '0;
      else if (cmd_valid && cmd_bank == BANK_W'(b))  bcnt <= BC_W'(BUSY_CYC);
      else if (bcnt != '0)                           bcnt <= bcnt - 1'b1;
    end
    assign bank_busy[b] = (bcnt != '0);
  end

  assign cpl_fire = cpl_valid && cpl_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_busy <= '0;
      t_rdy  <= '0;
    end else begin
      if (rsp_accept && !req_we) begin
        t_busy[ftag] <= 1'b1;
        t_line[ftag] <= req_addr[ADDR_W-1:LINE_LSB];
      end
      if (dram_rvalid) begin
        t_rdy[dram_rtag]  <= 1'b1;
        t_data[dram_rtag] <= dram_rdata;
      end
      if (cpl_fire) begin
        t_busy[cpl_tag] <= 1'b0;
        t_rdy[cpl_tag]  <= 1'b0;
      end
    end
  end

  assign cand = t_rdy & ~(cpl_valid ? (NTAG'(1) << cpl_tag) : NTAG'(0));

  always_comb begin
    sel = '0;
    for (int t = NTAG - 1; t >= 0; t--)
      if (cand[t]) sel = TAG_W'(t);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpl_valid <= 1'b0;
      cpl_tag   <= '0;
    end else if (!cpl_valid || cpl_ready) begin
      cpl_valid <= (cand != '0);
      cpl_tag   <= sel;
    end
  end

  assign cpl_data = t_data[cpl_tag];

  assert_tag_claimed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_accept && !req_we |=> t_busy[$past(rsp_tag)]);

  assert_queue_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= CNT_W'(QDEPTH));

  assert_bank_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !bank_busy[cmd_bank]);

  assert_cpl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_tag) && $stable(cpl_data));

  assert_cpl_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> t_busy[cpl_tag] && t_rdy[cpl_tag]);

  assert_return_owned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dram_rvalid |-> t_busy[dram_rtag] && !t_rdy[dram_rtag]);
endmodule

// File: tb/mem_sched_bench.sv
module mem_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0, req_coh = 0;
  logic [31:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic rsp_accept, rsp_retry;
  logic [3:0] rsp_tag;
  logic cmd_valid, cmd_we;
  logic [1:0] cmd_bank;
  logic [31:0] cmd_addr;
  logic [63:0] cmd_wdata;
  logic [3:0] cmd_tag;
  logic [3:0] bank_busy;
  logic dram_rvalid = 0;
  logic [3:0] dram_rtag = '0;
  logic [63:0] dram_rdata = '0;
  logic cpl_valid, cpl_ready = 0;
  logic [3:0] cpl_tag;
  logic [63:0] cpl_data;

  mem_sched u_mem_sched (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_we(req_we), .req_coh(req_coh),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_accept(rsp_accept), .rsp_retry(rsp_retry), .rsp_tag(rsp_tag),
    .cmd_valid(cmd_valid), .cmd_we(cmd_we), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_tag(cmd_tag),
    .bank_busy(bank_busy),
    .dram_rvalid(dram_rvalid), .dram_rtag(dram_rtag), .dram_rdata(dram_rdata),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_tag(cpl_tag), .cpl_data(cpl_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [63:0] mem [logic [31:0]];
  logic [63:0] shadow [logic [31:0]];
  logic [63:0] exp_data [16];
  int lg_cyc[$];
  logic [31:0] lg_addr[$];
  logic lg_we[$];
  int pend_due[$];
  logic [3:0] pend_tag[$];
  logic [63:0] pend_data[$];
  logic [3:0] got_tag[$];
  logic [63:0] got_data[$];

  function automatic logic [63:0] dval(logic [31:0] a);
    return {a ^ 32'h5A5A_5A5A, a};
  endfunction

  function automatic logic [63:0] rd_shadow(logic [31:0] a);
    return shadow.exists(a) ? shadow[a] : dval(a);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst_n && cmd_valid) begin
      lg_cyc.push_back(cyc); lg_addr.push_back(cmd_addr); lg_we.push_back(cmd_we);
      if (cmd_we) mem[cmd_addr] = cmd_wdata;
      else begin
        pend_due.push_back(cyc + LAT); pend_tag.push_back(cmd_tag);
        pend_data.push_back(mem.exists(cmd_addr) ? mem[cmd_addr] : dval(cmd_addr));
      end
    end
    if (rst_n && cpl_valid && cpl_ready) begin
      got_tag.push_back(cpl_tag); got_data.push_back(cpl_data);
    end
  end

  always @(negedge clk) begin
    dram_rvalid <= 1'b0;
    if (pend_due.size() > 0 && pend_due[0] <= cyc) begin
      dram_rvalid <= 1'b1;
      dram_rtag   <= pend_tag[0];
      dram_rdata  <= pend_data[0];
      void'(pend_due.pop_front()); void'(pend_tag.pop_front()); void'(pend_data.pop_front());
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send(input bit we, input bit coh, input logic [31:0] a, input logic [63:0] d,
                      output bit acc, output logic [3:0] tg);
    @(negedge clk);
    req_valid = 1; req_we = we; req_coh = coh; req_addr = a; req_wdata = d;
    #2;
    acc = rsp_accept; tg = rsp_tag;
    if (acc) begin
      if (we) shadow[a] = d;
      else exp_data[tg] = rd_shadow(a);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(input int n);
    cpl_ready = 1;
    for (int i = 0; i < 300 && got_tag.size() < n; i++) @(negedge clk);
    chk("R8", "completion count", 64'(got_tag.size()), 64'(n));
    foreach (got_tag[i]) chk("R8", $sformatf("data of tag %0d", got_tag[i]), got_data[i], exp_data[got_tag[i]]);
  endtask

  task automatic t_reset();
    @(negedge clk); #2;
    chk("R9", "cmd_valid", 64'(cmd_valid), 0);
    chk("R9", "cpl_valid", 64'(cpl_valid), 0);
    chk("R9", "bank_busy", 64'(bank_busy), 0);
  endtask

  task automatic t_basic();
    bit acc; logic [3:0] tg;
    got_tag.delete(); got_data.delete();
    send(1, 1, 32'h100, 64'hCAFE_0000_1111_2222, acc, tg);
    chk("R3", "write accept", 64'(acc), 1);
    send(0, 0, 32'h100, 0, acc, tg);
    chk("R1", "read accept", 64'(acc), 1);
    chk("R1", "first tag", 64'(tg), 0);
    send(0, 0, 32'h210, 0, acc, tg);
    chk("R1", "second tag", 64'(tg), 1);
    idle(0);
    drain(2);
    foreach (got_tag[i]) if (got_tag[i] == 0)
      chk("R7", "read after posted write", got_data[i], 64'hCAFE_0000_1111_2222);
  endtask

  task automatic t_bypass();
    bit acc; logic [3:0] tg;
    idle(10);
    got_tag.delete(); got_data.delete(); lg_cyc.delete(); lg_addr.delete(); lg_we.delete();
    send(0, 0, 32'h000, 0, acc, tg);
    send(0, 0, 32'h040, 0, acc, tg);
    send(0, 0, 32'h010, 0, acc, tg);
    idle(0);
    drain(3);
    chk("R6", "dispatch count", 64'(lg_addr.size()), 3);
    chk("R6", "first dispatch", 64'(lg_addr[0]), 64'h000);
    chk("R6", "bypass second", 64'(lg_addr[1]), 64'h010);
    chk("R5", "same-bank gap", 64'(lg_cyc[2] - lg_cyc[0]), 5);
  endtask

  task automatic t_full();
    bit acc; logic [3:0] tg; int first_retry = -1;
    idle(10);
    lg_addr.delete(); lg_cyc.delete(); lg_we.delete();
    for (int k = 0; k < 12; k++) begin
      send(1, 0, 32'h400 + 32'(k) * 32'h40, 64'(k), acc, tg);
      if (!acc && first_retry < 0) first_retry = k;
    end
    idle(80);
    chk("R2", "first retry on full queue", 64'(first_retry), 10);
    for (int i = 1; i < lg_addr.size(); i++)
      chk("R7", "same-bank order", 64'(lg_addr[i] > lg_addr[i-1]), 1);
  endtask

  task automatic t_tags();
    bit acc; logic [3:0] tg; logic [15:0] seen = '0;
    idle(10);
    got_tag.delete(); got_data.delete();
    cpl_ready = 0;
    for (int k = 0; k < 16; k++) begin
      acc = 0;
      for (int n = 0; n < 20 && !acc; n++) send(0, 0, 32'h800 + 32'(k) * 32'h10, 0, acc, tg);
      chk("R1", $sformatf("tag for read %0d", k), 64'(tg), 64'(k));
    end
    send(0, 0, 32'hF00, 0, acc, tg);
    chk("R2", "retry with no free tag", 64'(rsp_retry), 1);
    idle(40);
    drain(16);
    foreach (got_tag[i]) seen[got_tag[i]] = 1'b1;
    chk("R8", "each tag once", 64'(seen), 64'hFFFF);
  endtask

  task automatic t_coh();
    bit acc; logic [3:0] tg, t0; logic [63:0] d0;
    idle(10);
    got_tag.delete(); got_data.delete();
    cpl_ready = 0;
    send(0, 0, 32'h1000, 0, acc, t0);
    idle(15);
    chk("R8", "completion waiting", 64'(cpl_valid), 1);
    d0 = cpl_data;
    send(1, 1, 32'h1008, 64'h1, acc, tg);
    chk("R4", "coherent same line", 64'(acc), 0);
    send(1, 0, 32'h1008, 64'h2, acc, tg);
    chk("R4", "non-coherent same line", 64'(acc), 1);
    send(1, 1, 32'h2000, 64'h3, acc, tg);
    chk("R4", "coherent other line", 64'(acc), 1);
    idle(2);
    chk("R8", "held tag", 64'(cpl_tag), 64'(t0));
    chk("R8", "held data", cpl_data, d0);
    @(negedge clk);
    cpl_ready = 1;
    req_valid = 1; req_we = 1; req_coh = 1; req_addr = 32'h1010; req_wdata = 64'h4;
    #2;
    chk("R4", "handshake cycle valid", 64'(cpl_valid), 1);
    chk("R4", "retry in handshake cycle", 64'(rsp_retry), 1);
    send(1, 1, 32'h1010, 64'h4, acc, tg);
    chk("R4", "accept after completion", 64'(acc), 1);
    idle(0);
    chk("R8", "completed tag", 64'(got_tag.size() > 0 ? got_tag[0] : 4'hF), 64'(t0));
    chk("R8", "completed data", got_data.size() > 0 ? got_data[0] : 64'h0, dval(32'h1000));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_bypass();
    t_full();
    t_tags();
    t_coh();
    idle(20);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule